// File: doc/BRIEF.md
# Low-Power Mode Controller

This block manages the two power-saving modes of a small 8-bit microcontroller core. Software writes a two-bit request to a mode control register. Once that write completes, the controller stops the CPU clock (light sleep) or stops the oscillator as well (deep sleep). In light sleep the peripheral clock keeps running, so timers, the serial port and interrupt logic stay live. In deep sleep everything freezes, but stored state is kept.

The two modes exit differently. Light sleep ends as soon as any enabled interrupt is pending, and the core resumes in that interrupt's handler. Deep sleep ends only on a qualified reset. The reset pin counts as a reset only after it has been held high for two machine cycles of oscillator clocks. While a mode is active, the block also supplies override values for the address-latch and program-fetch strobes and for two ports. These values depend on whether code runs from external program memory.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), the state is run: `mode_bits`=00, `cpu_clk_en`=1, `per_clk_en`=1, `osc_en`=1, `pin_ovr_en`=0, `sys_rst`=0.
- R2: In run, a write with `mode_wdata`=01 enters light sleep at the next clock edge: `mode_bits`=01, `cpu_clk_en`=0, `per_clk_en`=1, `osc_en`=1.
- R3: In run, a write with `mode_wdata[1]`=1, with either value of bit 0, enters deep sleep at the next edge: `mode_bits`=10, `cpu_clk_en`=0, `per_clk_en`=0, and `osc_en`=0 while `rst_pin` is low.
- R4: In light sleep, any bit of `irq_req` being high returns the state to run at the next edge, and `mode_bits` reads 00.
- R5: In deep sleep, `irq_req` has no effect; the state stays deep sleep.
- R6: Mode writes made outside run are ignored.
- R7: `sys_rst` rises once `rst_pin` has been sampled high on RST_CYC = MC_CLKS*MC_PER_RST consecutive edges (24 by default). A low sample restarts the count, so 23 high edges leave the state unchanged.
- R8: While `sys_rst` is high, the next edge forces the state to run from any state, and this overrides a mode write in the same cycle.
- R9: `osc_en` is high whenever `rst_pin` is high, including in deep sleep, so the reset count can advance.
- R10: In either sleep mode `pin_ovr_en`=1; `ale_ovr` and `psen_ovr` are 1 in light sleep and 0 in deep sleep.
- R11: `p0_float` is 1 only in a sleep mode with `ext_code`=1. `p2_addr` is 1 only in light sleep with `ext_code`=1; otherwise port 2 holds its latched data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | Raw external reset pin, active high |
| mode_wr | input | 1 | Mode control register write strobe |
| mode_wdata | input | 2 | Bit 0 requests light sleep, bit 1 requests deep sleep |
| irq_req | input | NIRQ | Enabled, pending interrupt flags |
| ext_code | input | 1 | 1 when executing from external program memory |
| sys_rst | output | 1 | Qualified reset |
| mode_bits | output | 2 | Mode control bits; bit 1 = deep sleep, bit 0 = light sleep |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| pin_ovr_en | output | 1 | Strobe and port overrides active |
| ale_ovr | output | 1 | Forced address-latch strobe level |
| psen_ovr | output | 1 | Forced program-fetch strobe level |
| p0_float | output | 1 | Port 0 released to high impedance |
| p2_addr | output | 1 | Port 2 keeps driving the address |

## Verification
A reset can complete qualification in the same cycle that software writes a mode request, and the reset must win. The bench provokes this by holding `rst_pin` high for exactly RST_CYC edges and then pulsing `mode_wr` in the cycle where `sys_rst` first reads high. It judges the result by requiring `mode_bits`=00 and the clocks enabled after the next edge. A wake interrupt that coincides with a reset burst in light sleep, and random overlap of writes, interrupts and reset bursts, are compared cycle by cycle against a bench model.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_state_e;

  // oscillator edges needed to qualify a reset
  function automatic int unsigned rst_hold_clks(int unsigned mc_clks, int unsigned n_mc);
    return mc_clks * n_mc;
  endfunction

  // next mode: qualified reset first, then wake, then a write from run
  function automatic pm_state_e pm_next(pm_state_e cur, logic rst_q, logic wr,
                                        logic [1:0] req, logic wake);
    pm_state_e nx;
    nx = cur;
    if (rst_q) nx = PM_RUN;
    else begin
      case (cur)
        PM_RUN: begin
          if (wr && req[1]) nx = PM_DOWN;
          else if (wr && req[0]) nx = PM_IDLE;
        end
        PM_IDLE: if (wake) nx = PM_RUN;
        default: nx = cur;
      endcase
    end
    return nx;
  endfunction
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int unsigned RST_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin,
  output logic rst_q
);
  localparam int unsigned CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(RST_CYC);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_cnt <= '0;
    else if (!rst_pin) hold_cnt <= '0;
    else if (hold_cnt != CMAX) hold_cnt <= hold_cnt + 1'b1;
  end

  assign rst_q = (hold_cnt == CMAX);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int unsigned NIRQ = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_q,
  input  logic            mode_wr,
  input  logic [1:0]      mode_wdata,
  input  logic [NIRQ-1:0] irq_req,
  output pm_state_e       state,
  output logic            enter_idle,
  output logic            enter_down,
  output logic            wake_evt
);
  logic      wake;
  pm_state_e state_n;

  assign wake    = |irq_req;
  assign state_n = pm_next(state, rst_q, mode_wr, mode_wdata, wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PM_RUN;
    else        state <= state_n;
  end

  assign enter_idle = (state == PM_RUN)  && (state_n == PM_IDLE);
  assign enter_down = (state == PM_RUN)  && (state_n == PM_DOWN);
  assign wake_evt   = (state == PM_IDLE) && (state_n == PM_RUN) && !rst_q;
endmodule

// File: rtl/pmc_pin_ovr.sv
module pmc_pin_ovr
  import pmc_pkg::*;
(
  input  pm_state_e state,
  input  logic      ext_code,
  input  logic      rst_pin,
  output logic      cpu_clk_en,
  output logic      per_clk_en,
  output logic      osc_en,
  output logic      pin_ovr_en,
  output logic      ale_ovr,
  output logic      psen_ovr,
  output logic      p0_float,
  output logic      p2_addr
);
  logic in_idle, in_down;

  assign in_idle    = (state == PM_IDLE);
  assign in_down    = (state == PM_DOWN);
  assign cpu_clk_en = !in_idle && !in_down;
  assign per_clk_en = !in_down;
  assign osc_en     = !in_down || rst_pin;
  assign pin_ovr_en = in_idle || in_down;
  assign ale_ovr    = in_idle;
  assign psen_ovr   = in_idle;
  assign p0_float   = pin_ovr_en && ext_code;
  assign p2_addr    = in_idle && ext_code;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned NIRQ       = 6,
  parameter int unsigned MC_CLKS    = 12,
  parameter int unsigned MC_PER_RST = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pin,
  input  logic            mode_wr,
  input  logic [1:0]      mode_wdata,
  input  logic [NIRQ-1:0] irq_req,
  input  logic            ext_code,
  output logic            sys_rst,
  output logic [1:0]      mode_bits,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            osc_en,
  output logic            pin_ovr_en,
  output logic            ale_ovr,
  output logic            psen_ovr,
  output logic            p0_float,
  output logic            p2_addr
);
  localparam int unsigned RST_CYC = rst_hold_clks(MC_CLKS, MC_PER_RST);

  pm_state_e state;
  logic      enter_idle, enter_down, wake_evt;

  pmc_rst_qual #(.RST_CYC(RST_CYC)) u_rq (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .rst_q(sys_rst)
  );

  pmc_mode_fsm #(.NIRQ(NIRQ)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rst_q(sys_rst), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .irq_req(irq_req), .state(state),
    .enter_idle(enter_idle), .enter_down(enter_down), .wake_evt(wake_evt)
  );

  pmc_pin_ovr u_ovr (
    .state(state), .ext_code(ext_code), .rst_pin(rst_pin),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .pin_ovr_en(pin_ovr_en), .ale_ovr(ale_ovr), .psen_ovr(psen_ovr),
    .p0_float(p0_float), .p2_addr(p2_addr)
  );

  assign mode_bits = {state == PM_DOWN, state == PM_IDLE};
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int unsigned NIRQ = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_pin,
  input logic [NIRQ-1:0] irq_req,
  input logic            sys_rst,
  input logic [1:0]      mode_bits,
  input logic            osc_en,
  input logic            cpu_clk_en,
  input logic            enter_idle,
  input logic            enter_down,
  input logic            wake_evt
);
  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enter_idle |=> (mode_bits == 2'b01 && !cpu_clk_en));
  assert_down_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enter_down |=> (mode_bits == 2'b10));
  assert_idle_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits[0] && (|irq_req) && !sys_rst) |=> (mode_bits == 2'b00 && cpu_clk_en));
  assert_wake_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> (|irq_req));
  assert_down_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits[1] && !sys_rst) |=> mode_bits[1]);
  assert_rst_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(rst_pin));
  assert_rst_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (mode_bits == 2'b00));
  assert_osc_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin |-> osc_en);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .irq_req(irq_req),
  .sys_rst(sys_rst), .mode_bits(mode_bits), .osc_en(osc_en),
  .cpu_clk_en(cpu_clk_en), .enter_idle(enter_idle),
  .enter_down(enter_down), .wake_evt(wake_evt)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  localparam int NIRQ = 6;
  localparam int RST_CYC = 24;

  logic clk = 1'b0;
  logic rst_n, rst_pin, mode_wr, ext_code;
  logic [1:0] mode_wdata;
  logic [NIRQ-1:0] irq_req;
  logic sys_rst, cpu_clk_en, per_clk_en, osc_en, pin_ovr_en;
  logic ale_ovr, psen_ovr, p0_float, p2_addr;
  logic [1:0] mode_bits;

  int n_tests = 0;
  int n_fail = 0;
  int m_st = 0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.NIRQ(NIRQ)) dut (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .irq_req(irq_req), .ext_code(ext_code),
    .sys_rst(sys_rst), .mode_bits(mode_bits), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .pin_ovr_en(pin_ovr_en),
    .ale_ovr(ale_ovr), .psen_ovr(psen_ovr), .p0_float(p0_float), .p2_addr(p2_addr)
  );

  // expected outputs {sys_rst, mode[1:0], cpu, per, osc, ovr, ale, psen, p0f, p2a}
  function automatic logic [10:0] exp_out(int st, int cnt, logic pin, logic ext);
    logic idle, down;
    idle = (st == 1);
    down = (st == 2);
    return {cnt == RST_CYC, down, idle, !(idle || down), !down, (!down) || pin,
            idle || down, idle, idle, (idle || down) && ext, idle && ext};
  endfunction

  function automatic int model_next(int st, int cnt, logic wr, logic [1:0] d, logic [NIRQ-1:0] irq);
    if (cnt == RST_CYC) return 0;
    if (st == 0 && wr) return d[1] ? 2 : (d[0] ? 1 : 0);
    if (st == 1 && (|irq)) return 0;
    return st;
  endfunction

  // advance one clock with current inputs, then compare at the falling edge
  task automatic step(input string tag);
    logic [10:0] e, a;
    m_st  = model_next(m_st, m_cnt, mode_wr, mode_wdata, irq_req);
    m_cnt = rst_pin ? ((m_cnt == RST_CYC) ? RST_CYC : m_cnt + 1) : 0;
    @(negedge clk);
    e = exp_out(m_st, m_cnt, rst_pin, ext_code);
    a = {sys_rst, mode_bits, cpu_clk_en, per_clk_en, osc_en, pin_ovr_en,
         ale_ovr, psen_ovr, p0_float, p2_addr};
    n_tests++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: outputs actual=%b expected=%b", tag, a, e);
    end
  endtask

  task automatic wr_mode(input logic [1:0] d, input string tag);
    mode_wr = 1'b1; mode_wdata = d;
    step(tag);
    mode_wr = 1'b0; mode_wdata = 2'b00;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int burst;
    rst_n = 1'b0; rst_pin = 1'b0; mode_wr = 1'b0; mode_wdata = 2'b00;
    irq_req = '0; ext_code = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: power-on state
    step("R1");
    step("R1");
    // R2: light sleep entry, clocks held
    wr_mode(2'b01, "R2");
    step("R2");
    // R6: write while asleep ignored
    wr_mode(2'b10, "R6");
    // R4: wake on single interrupt bit
    irq_req = 6'b100000;
    step("R4");
    irq_req = '0;
    // R3: deep sleep, both bits written
    wr_mode(2'b11, "R3");
    // R5: interrupts ignored in deep sleep
    irq_req = '1;
    repeat (3) step("R5");
    irq_req = '0;
    // R11: port overrides, external code, deep sleep
    ext_code = 1'b1;
    step("R11");
    // R9: oscillator runs while reset pin high; R7 count
    rst_pin = 1'b1;
    repeat (RST_CYC - 1) step("R9");
    step("R7");
    // R8: qualified reset wins over same-cycle write
    wr_mode(2'b10, "R8");
    rst_pin = 1'b0;
    step("R8");
    // R10 / R11: light sleep with external code
    wr_mode(2'b01, "R10");
    step("R11");
    // R7: 23-edge pulse does nothing
    rst_pin = 1'b1;
    repeat (RST_CYC - 1) step("R7");
    rst_pin = 1'b0;
    step("R7");
    // R11: internal code in light sleep
    ext_code = 1'b0;
    step("R11");
    // wake coinciding with reset burst
    rst_pin = 1'b1;
    irq_req = 6'b000001;
    repeat (RST_CYC + 2) step("R4");
    rst_pin = 1'b0; irq_req = '0;
    step("R8");
    // R2 vs R3 priority single bit down
    wr_mode(2'b10, "R3");
    step("R10");
    rst_pin = 1'b1;
    repeat (RST_CYC + 1) step("R8");
    rst_pin = 1'b0;
    step("R8");
    // random mix
    burst = 0;
    for (int i = 0; i < 4000; i++) begin
      mode_wr    = ($urandom % 6) == 0;
      mode_wdata = 2'($urandom);
      irq_req    = (($urandom % 8) == 0) ? NIRQ'($urandom) : '0;
      ext_code   = ($urandom % 2) == 1;
      if (burst > 0) burst--;
      else if (($urandom % 60) == 0) burst = 15 + int'($urandom % 20);
      rst_pin = (burst > 0);
      step("Rmix");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule